// File: doc/BRIEF.md
# Descriptor Completion Write-Back Generator

This block follows a single streaming-to-memory packet transfer and, when the transfer finishes, produces the record that is written back into the linked-list descriptor that described it. A start pulse arms the block with the programmed transfer length, the control word as it was fetched, and the park-mode setting. While armed, the block accepts beats from a streaming sink. It counts the bytes that fall between start-of-packet and end-of-packet, merges the error codes seen on those beats, and stops early if the programmed length is used up before end-of-packet arrives.

On completion the block offers the finished record on a valid/ready output. The record holds the byte count, a 16-bit status word (error code plus an early-termination flag), the control word with its ownership bit handed back to software unless park mode is set, and, when sideband support is built in, three 32-bit sideband words taken from a response input. The record stays unchanged until the consumer takes it. The block then waits for the next start pulse.

Top module: `desc_wb_gen`

## Requirements
- R1: After reset, snkReady and wbValid are both 0.
- R2: A startPulse while the block is idle (snkReady=0, wbValid=0) makes snkReady 1 from the next cycle. A startPulse at any other time is ignored and leaves the held record unchanged.
- R3: wbActualBytes counts accepted beats from the start-of-packet beat through the end-of-packet beat inclusive. Each beat adds DATA_BYTES, except the end-of-packet beat, which adds DATA_BYTES minus snkEmpty. Beats accepted before any start-of-packet add nothing.
- R4: Status bits 7:0 hold the bitwise OR of snkError over all counted beats of the packet. The value is cleared at start-of-packet.
- R5: Status bit 8 is 1 when a counted beat without end-of-packet brings the count to at least the programmed length, and that beat ends the transfer. If the beat that reaches the length carries end-of-packet, bit 8 is 0.
- R6: Once a transfer ends, snkReady stays 0 until the record has been taken and a new startPulse arrives. snkReady and wbValid are never 1 together.
- R7: Status bits 15:9 are always 0.
- R8: wbCtrl bits 31 and 29:0 equal the fetched control word. Bit 30, the ownership bit, is 0 when park mode was off at start, and equals the fetched bit 30 when park mode was on.
- R9: With SB_EN=1, wbSideband[31:0], [63:32] and [95:64] equal respData[191:160], [223:192] and [255:224] as sampled on the beat that ended the transfer. wbSidebandWe is 1 whenever wbValid is 1.
- R10: With SB_EN=0, wbSidebandWe stays 0 and wbSideband is 0.
- R11: The record appears with wbValid=1 in the cycle after the ending beat. It stays valid and unchanged while wbReady is 0. The cycle after a wbReady=1 handshake, wbValid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Arms a new transfer when idle |
| xferLen | input | LEN_W | Programmed transfer length in bytes |
| fetchedCtrl | input | 32 | Control word as fetched |
| parkMode | input | 1 | Park mode: keep ownership bit on write-back |
| snkValid | input | 1 | Sink beat valid |
| snkReady | output | 1 | Sink ready |
| snkSop | input | 1 | Start-of-packet |
| snkEop | input | 1 | End-of-packet |
| snkEmpty | input | EMPTY_W | Unused bytes in the end-of-packet beat |
| snkError | input | ERR_W | Stream error code |
| respData | input | RESP_W-160 (bits RESP_W-1:160) | Upper part of the response bus carrying sideband |
| wbValid | output | 1 | Record valid |
| wbReady | input | 1 | Record accepted by consumer |
| wbActualBytes | output | LEN_W | Bytes counted |
| wbStatus | output | 16 | Status word |
| wbCtrl | output | 32 | Control word for write-back |
| wbSideband | output | 96 | Three sideband words |
| wbSidebandWe | output | 1 | Sideband words are written |

## Verification
snkReady is due in the cycle after an idle start pulse. The full record with wbValid is due in the cycle after the beat that ends the transfer. wbValid falls in the cycle after the handshake. The bench drives every input on the falling edge and samples on the next falling edge, so each of these one-register delays is observed exactly one clock after the stimulus that causes it. Its reference model updates the expected count, error, early flag and sideband on the same beats the design accepts, and it then compares the whole record at that point and again at every cycle the record is held.

// File: rtl/desc_wb_pkg.sv
`timescale 1ns/1ps
package desc_wb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WB   = 2'd2
  } wbState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch descriptor info, clear record
    logic sopBeat;  // counted beat that opens a packet
    logic midBeat;  // counted beat inside a packet
    logic finish;   // this beat ends the transfer
    logic early;    // ending is an early termination
  } wbStrobe_t;

  localparam int STATUS_W    = 16;
  localparam int CTRL_W      = 32;
  localparam int OWN_BIT     = 30;
  localparam int SB_WORDS    = 3;
  localparam int SB_WORD_W   = 32;
  localparam int SB_LSB      = 160;

endpackage

// File: rtl/desc_wb_ctrl.sv
`timescale 1ns/1ps
module desc_wb_ctrl
  import desc_wb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      startPulse,
  input  logic      snkValid,
  input  logic      snkSop,
  input  logic      snkEop,
  input  logic      lenHit,
  input  logic      wbReady,
  output logic      snkReady,
  output logic      wbValid,
  output wbStrobe_t strobe
);

  wbState_t state, nextState;
  logic     inPkt, inPktNext;
  logic     take;

  assign take = (state == ST_RUN) && snkValid && (snkSop || inPkt);

  always_comb begin
    strobe    = '0;
    nextState = state;
    inPktNext = inPkt;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobe.load = 1'b1;
          inPktNext   = 1'b0;
          nextState   = ST_RUN;
        end
      end
      ST_RUN: begin
        if (take) begin
          strobe.sopBeat = snkSop;
          strobe.midBeat = !snkSop;
          inPktNext      = 1'b1;
          if (snkEop) begin
            strobe.finish = 1'b1;
            inPktNext     = 1'b0;
            nextState     = ST_WB;
          end else if (lenHit) begin
            strobe.finish = 1'b1;
            strobe.early  = 1'b1;
            inPktNext     = 1'b0;
            nextState     = ST_WB;
          end
        end
      end
      ST_WB: begin
        if (wbReady) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      inPkt <= 1'b0;
    end else begin
      state <= nextState;
      inPkt <= inPktNext;
    end
  end

  assign snkReady = (state == ST_RUN);
  assign wbValid  = (state == ST_WB);

endmodule

// File: rtl/desc_wb_datapath.sv
`timescale 1ns/1ps
module desc_wb_datapath
  import desc_wb_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int LEN_W      = 32,
  parameter int ERR_W      = 8,
  parameter int RESP_W     = 256,
  parameter bit SB_EN      = 1'b1,
  localparam int EMPTY_W   = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  wbStrobe_t                strobe,
  input  logic [LEN_W-1:0]         xferLen,
  input  logic [CTRL_W-1:0]        fetchedCtrl,
  input  logic                     parkMode,
  input  logic                     snkSop,
  input  logic                     snkEop,
  input  logic [EMPTY_W-1:0]       snkEmpty,
  input  logic [ERR_W-1:0]         snkError,
  input  logic [RESP_W-1:SB_LSB]   respData,
  output logic                     lenHit,
  output logic [LEN_W-1:0]         actualBytes,
  output logic [STATUS_W-1:0]      status,
  output logic [CTRL_W-1:0]        ctrlWord,
  output logic [SB_WORDS*SB_WORD_W-1:0] sideband
);

  localparam int RSV_W = STATUS_W - 1 - ERR_W;

  logic [LEN_W-1:0]  lenReg;
  logic [CTRL_W-1:0] ctrlReg;
  logic              parkReg;
  logic [LEN_W-1:0]  countReg;
  logic [ERR_W-1:0]  errReg;
  logic              earlyReg;

  logic [LEN_W-1:0]  beatAdd;
  logic [LEN_W-1:0]  countBase;
  logic [LEN_W-1:0]  countSum;

  always_comb begin
    beatAdd   = snkEop ? (LEN_W'(DATA_BYTES) - LEN_W'(snkEmpty)) : LEN_W'(DATA_BYTES);
    countBase = snkSop ? '0 : countReg;
    countSum  = countBase + beatAdd;
  end

  assign lenHit = (countSum >= lenReg);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lenReg   <= '0;
      ctrlReg  <= '0;
      parkReg  <= 1'b0;
      countReg <= '0;
      errReg   <= '0;
      earlyReg <= 1'b0;
    end else if (strobe.load) begin
      lenReg   <= xferLen;
      ctrlReg  <= fetchedCtrl;
      parkReg  <= parkMode;
      countReg <= '0;
      errReg   <= '0;
      earlyReg <= 1'b0;
    end else begin
      if (strobe.sopBeat) begin
        countReg <= countSum;
        errReg   <= snkError;
      end else if (strobe.midBeat) begin
        countReg <= countSum;
        errReg   <= errReg | snkError;
      end
      if (strobe.finish) earlyReg <= strobe.early;
    end
  end

  generate
    if (SB_EN) begin : g_sideband
      for (genvar w = 0; w < SB_WORDS; w++) begin : g_word
        logic [SB_WORD_W-1:0] sbReg;
        always_ff @(posedge clk) begin
          if (!rst_n)             sbReg <= '0;
          else if (strobe.load)   sbReg <= '0;
          else if (strobe.finish) sbReg <= respData[SB_LSB + w*SB_WORD_W +: SB_WORD_W];
        end
        assign sideband[w*SB_WORD_W +: SB_WORD_W] = sbReg;
      end
    end else begin : g_no_sideband
      assign sideband = '0;
    end
  endgenerate

  assign actualBytes = countReg;
  assign status      = {{RSV_W{1'b0}}, earlyReg, errReg};
  assign ctrlWord    = {ctrlReg[CTRL_W-1],
                        parkReg ? ctrlReg[OWN_BIT] : 1'b0,
                        ctrlReg[OWN_BIT-1:0]};

endmodule

// File: rtl/desc_wb_gen.sv
`timescale 1ns/1ps
module desc_wb_gen
  import desc_wb_pkg::*;
#(
  parameter int DATA_BYTES = 8,
  parameter int LEN_W      = 32,
  parameter int ERR_W      = 8,
  parameter int RESP_W     = 256,
  parameter bit SB_EN      = 1'b1,
  localparam int EMPTY_W   = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   startPulse,
  input  logic [LEN_W-1:0]       xferLen,
  input  logic [31:0]            fetchedCtrl,
  input  logic                   parkMode,
  input  logic                   snkValid,
  output logic                   snkReady,
  input  logic                   snkSop,
  input  logic                   snkEop,
  input  logic [EMPTY_W-1:0]     snkEmpty,
  input  logic [ERR_W-1:0]       snkError,
  input  logic [RESP_W-1:160]    respData,
  output logic                   wbValid,
  input  logic                   wbReady,
  output logic [LEN_W-1:0]       wbActualBytes,
  output logic [15:0]            wbStatus,
  output logic [31:0]            wbCtrl,
  output logic [95:0]            wbSideband,
  output logic                   wbSidebandWe
);

  wbStrobe_t strobe;
  logic      lenHit;

  desc_wb_ctrl i_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startPulse (startPulse),
    .snkValid   (snkValid),
    .snkSop     (snkSop),
    .snkEop     (snkEop),
    .lenHit     (lenHit),
    .wbReady    (wbReady),
    .snkReady   (snkReady),
    .wbValid    (wbValid),
    .strobe     (strobe)
  );

  desc_wb_datapath #(
    .DATA_BYTES (DATA_BYTES),
    .LEN_W      (LEN_W),
    .ERR_W      (ERR_W),
    .RESP_W     (RESP_W),
    .SB_EN      (SB_EN)
  ) i_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .xferLen     (xferLen),
    .fetchedCtrl (fetchedCtrl),
    .parkMode    (parkMode),
    .snkSop      (snkSop),
    .snkEop      (snkEop),
    .snkEmpty    (snkEmpty),
    .snkError    (snkError),
    .respData    (respData),
    .lenHit      (lenHit),
    .actualBytes (wbActualBytes),
    .status      (wbStatus),
    .ctrlWord    (wbCtrl),
    .sideband    (wbSideband)
  );

  assign wbSidebandWe = SB_EN && wbValid;

endmodule

// File: rtl/desc_wb_checker.sv
`timescale 1ns/1ps
module desc_wb_checker #(
  parameter int LEN_W = 32,
  parameter bit SB_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             startPulse,
  input logic [LEN_W-1:0] xferLen,
  input logic [31:0]      fetchedCtrl,
  input logic             parkMode,
  input logic             snkReady,
  input logic             wbValid,
  input logic             wbReady,
  input logic [LEN_W-1:0] wbActualBytes,
  input logic [15:0]      wbStatus,
  input logic [31:0]      wbCtrl,
  input logic [95:0]      wbSideband,
  input logic             wbSidebandWe
);

  logic [31:0]      shCtrl;
  logic             shPark;
  logic [LEN_W-1:0] shLen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shCtrl <= '0;
      shPark <= 1'b0;
      shLen  <= '0;
    end else if (startPulse && !snkReady && !wbValid) begin
      shCtrl <= fetchedCtrl;
      shPark <= parkMode;
      shLen  <= xferLen;
    end
  end

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(snkReady && wbValid));

  assert_ready_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!snkReady && !startPulse) |=> !snkReady);

  assert_early_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && wbStatus[8]) |-> (wbActualBytes >= shLen));

  assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> (wbStatus[15:9] == 7'd0));

  assert_ctrl_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wbValid |-> (wbCtrl == {shCtrl[31], shPark & shCtrl[30], shCtrl[29:0]}));

  assert_record_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && !wbReady) |=> (wbValid && $stable(wbStatus) && $stable(wbActualBytes)
                               && $stable(wbCtrl) && $stable(wbSideband)));

  assert_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wbValid && wbReady) |=> !wbValid);

  generate
    if (SB_EN) begin : g_sb_on
      assert_sb_we_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wbValid |-> wbSidebandWe);
    end else begin : g_sb_off
      assert_sb_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wbSidebandWe && (wbSideband == 96'd0));
    end
  endgenerate

endmodule

bind desc_wb_gen desc_wb_checker #(
  .LEN_W (LEN_W),
  .SB_EN (SB_EN)
) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .startPulse    (startPulse),
  .xferLen       (xferLen),
  .fetchedCtrl   (fetchedCtrl),
  .parkMode      (parkMode),
  .snkReady      (snkReady),
  .wbValid       (wbValid),
  .wbReady       (wbReady),
  .wbActualBytes (wbActualBytes),
  .wbStatus      (wbStatus),
  .wbCtrl        (wbCtrl),
  .wbSideband    (wbSideband),
  .wbSidebandWe  (wbSidebandWe)
);

// File: tb/test_desc_wb_gen.sv
`timescale 1ns/1ps
module test_desc_wb_gen;

  localparam int DATA_BYTES = 8;
  localparam int LEN_W      = 32;
  localparam int EMPTY_W    = 3;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               startPulse = 1'b0;
  logic [LEN_W-1:0]   xferLen = '0;
  logic [31:0]        fetchedCtrl = '0;
  logic               parkMode = 1'b0;
  logic               snkValid = 1'b0;
  logic               snkSop = 1'b0;
  logic               snkEop = 1'b0;
  logic [EMPTY_W-1:0] snkEmpty = '0;
  logic [7:0]         snkError = '0;
  logic [255:160]     respData = '0;
  logic               wbReady = 1'b0;

  logic               snkReady, wbValid, wbSidebandWe;
  logic [LEN_W-1:0]   wbActualBytes;
  logic [15:0]        wbStatus;
  logic [31:0]        wbCtrl;
  logic [95:0]        wbSideband;

  logic               nsReady, nsValid, nsWe;
  logic [LEN_W-1:0]   nsBytes;
  logic [15:0]        nsStatus;
  logic [31:0]        nsCtrl;
  logic [95:0]        nsSideband;

  always #10 clk = ~clk;  // 50 MHz

  desc_wb_gen #(.DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W), .SB_EN(1'b1)) i_desc_wb_gen (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .xferLen(xferLen),
    .fetchedCtrl(fetchedCtrl), .parkMode(parkMode), .snkValid(snkValid),
    .snkReady(snkReady), .snkSop(snkSop), .snkEop(snkEop), .snkEmpty(snkEmpty),
    .snkError(snkError), .respData(respData), .wbValid(wbValid), .wbReady(wbReady),
    .wbActualBytes(wbActualBytes), .wbStatus(wbStatus), .wbCtrl(wbCtrl),
    .wbSideband(wbSideband), .wbSidebandWe(wbSidebandWe));

  desc_wb_gen #(.DATA_BYTES(DATA_BYTES), .LEN_W(LEN_W), .SB_EN(1'b0)) i_desc_wb_gen_nosb (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .xferLen(xferLen),
    .fetchedCtrl(fetchedCtrl), .parkMode(parkMode), .snkValid(snkValid),
    .snkReady(nsReady), .snkSop(snkSop), .snkEop(snkEop), .snkEmpty(snkEmpty),
    .snkError(snkError), .respData(respData), .wbValid(nsValid), .wbReady(wbReady),
    .wbActualBytes(nsBytes), .wbStatus(nsStatus), .wbCtrl(nsCtrl),
    .wbSideband(nsSideband), .wbSidebandWe(nsWe));

  int nChecks = 0;
  int nErrors = 0;

  // reference model state
  logic [LEN_W-1:0] mLen;
  logic [31:0]      mCtrl;
  logic             mPark;
  logic [LEN_W-1:0] mCount;
  logic [7:0]       mErr;
  logic             mEarly;
  logic             mInPkt;
  logic             mDone;
  logic [95:0]      mSb;

  task automatic checkEq(string req, string what, logic [127:0] act, logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LEN_W-1:0] beatBytes(logic eop, logic [EMPTY_W-1:0] empty);
    return eop ? LEN_W'(DATA_BYTES - int'(empty)) : LEN_W'(DATA_BYTES);
  endfunction

  function automatic logic [31:0] expCtrl(logic [31:0] c, logic park);
    return {c[31], park & c[30], c[29:0]};
  endfunction

  task automatic startXfer(logic [LEN_W-1:0] len, logic [31:0] ctrl, logic park);
    startPulse = 1'b1; xferLen = len; fetchedCtrl = ctrl; parkMode = park;
    mLen = len; mCtrl = ctrl; mPark = park;
    mCount = '0; mErr = '0; mEarly = 1'b0; mInPkt = 1'b0; mDone = 1'b0; mSb = '0;
    @(negedge clk);
    startPulse = 1'b0;
    checkEq("R2", "snkReady after start", snkReady, 1'b1);
  endtask

  // drive one beat at a falling edge; model it; advance to next falling edge
  task automatic beat(logic v, logic sop, logic eop, logic [EMPTY_W-1:0] empty, logic [7:0] err);
    logic [95:0]      rd;
    logic [LEN_W-1:0] sum;
    rd = {$urandom(), $urandom(), $urandom()};
    snkValid = v; snkSop = sop; snkEop = eop; snkEmpty = empty; snkError = err;
    respData = rd;
    if (v && !mDone && (sop || mInPkt)) begin
      sum = (sop ? '0 : mCount) + beatBytes(eop, empty);
      mErr   = sop ? err : (mErr | err);
      mCount = sum;
      mInPkt = 1'b1;
      if (eop) begin
        mDone = 1'b1; mEarly = 1'b0; mSb = rd; mInPkt = 1'b0;
      end else if (sum >= mLen) begin
        mDone = 1'b1; mEarly = 1'b1; mSb = rd; mInPkt = 1'b0;
      end
    end
    @(negedge clk);
    snkValid = 1'b0; snkSop = 1'b0; snkEop = 1'b0;
  endtask

  task automatic checkRecord();
    checkEq("R11", "wbValid", wbValid, 1'b1);
    checkEq("R6",  "snkReady low while record held", snkReady, 1'b0);
    checkEq("R3",  "actual bytes", wbActualBytes, mCount);
    checkEq("R4",  "status error", wbStatus[7:0], mErr);
    checkEq("R5",  "early flag", wbStatus[8], mEarly);
    checkEq("R7",  "reserved status", wbStatus[15:9], 7'd0);
    checkEq("R8",  "control word", wbCtrl, expCtrl(mCtrl, mPark));
    checkEq("R9",  "sideband words", wbSideband, mSb);
    checkEq("R9",  "sideband write enable", wbSidebandWe, 1'b1);
    checkEq("R10", "no-sideband write enable", nsWe, 1'b0);
    checkEq("R10", "no-sideband words", nsSideband, 96'd0);
    checkEq("R3",  "no-sideband bytes", nsBytes, mCount);
  endtask

  task automatic finishRecord(int holdCycles);
    for (int i = 0; i < holdCycles; i++) begin
      // stray start and beats while held must change nothing
      startPulse = (i == 0); fetchedCtrl = ~mCtrl; xferLen = mLen + 1; parkMode = ~mPark;
      beat(1'b1, 1'b1, 1'b1, '0, 8'hFF);
      startPulse = 1'b0;
      checkEq("R11", "record held valid", wbValid, 1'b1);
      checkEq("R2",  "start ignored, bytes", wbActualBytes, mCount);
      checkEq("R2",  "start ignored, ctrl", wbCtrl, expCtrl(mCtrl, mPark));
      checkEq("R11", "record held status", wbStatus, {7'd0, mEarly, mErr});
    end
    wbReady = 1'b1;
    @(negedge clk);
    wbReady = 1'b0;
    checkEq("R11", "wbValid after handshake", wbValid, 1'b0);
    checkEq("R6",  "snkReady idle after handshake", snkReady, 1'b0);
    @(negedge clk);
    checkEq("R6", "snkReady stays low without start", snkReady, 1'b0);
  endtask

  task automatic randomXfer();
    int nJunk, nBeats, gap;
    logic [7:0] e;
    startXfer(LEN_W'($urandom_range(1, 48)), $urandom(), 1'($urandom_range(0, 1)));
    nJunk = $urandom_range(0, 2);
    for (int j = 0; j < nJunk; j++)
      beat(1'b1, 1'b0, 1'($urandom_range(0, 1)), EMPTY_W'($urandom()), 8'($urandom()));
    nBeats = $urandom_range(1, 8);
    for (int b = 0; b < nBeats && !mDone; b++) begin
      gap = $urandom_range(0, 2);
      for (int g = 0; g < gap; g++) beat(1'b0, 1'b0, 1'b0, '0, 8'hAA);
      e = ($urandom_range(0, 3) == 0) ? (8'd1 << $urandom_range(0, 7)) : 8'd0;
      beat(1'b1, b == 0, b == nBeats - 1, EMPTY_W'($urandom()), e);
    end
    checkRecord();
    finishRecord($urandom_range(0, 3));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    nChecks++;
    $display("FAIL watchdog (R11 handshake) expired: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    checkEq("R1", "snkReady in reset", snkReady, 1'b0);
    checkEq("R1", "wbValid in reset", wbValid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    checkEq("R1", "snkReady after reset", snkReady, 1'b0);
    checkEq("R1", "wbValid after reset", wbValid, 1'b0);

    // single beat with empty, reaches length exactly on EOP: no early (R5, R3)
    startXfer(32'd5, 32'hC000_1234, 1'b0);
    beat(1'b1, 1'b1, 1'b1, 3'd3, 8'h21);
    checkRecord();
    checkEq("R5", "EOP at length gives no early flag", wbStatus[8], 1'b0);
    finishRecord(1);

    // early termination at 16 bytes, no EOP (R5, R6), park on keeps ownership (R8)
    startXfer(32'd16, 32'h4000_00FF, 1'b1);
    beat(1'b1, 1'b1, 1'b0, '0, 8'h01);
    beat(1'b1, 1'b0, 1'b0, '0, 8'h80);
    checkRecord();
    checkEq("R5", "early flag at length", wbStatus[8], 1'b1);
    checkEq("R4", "OR of errors", wbStatus[7:0], 8'h81);
    checkEq("R8", "park keeps ownership bit", wbCtrl[30], 1'b1);
    finishRecord(2);

    // park off clears ownership bit; junk beats before SOP ignored (R3, R8)
    startXfer(32'd100, 32'hFFFF_FFFF, 1'b0);
    beat(1'b1, 1'b0, 1'b1, 3'd0, 8'h44);
    beat(1'b1, 1'b1, 1'b0, '0, 8'h02);
    beat(1'b1, 1'b0, 1'b1, 3'd7, 8'h00);
    checkRecord();
    checkEq("R3", "junk beats excluded", wbActualBytes, 32'd9);
    checkEq("R4", "pre-SOP error excluded", wbStatus[7:0], 8'h02);
    checkEq("R8", "ownership cleared", wbCtrl, 32'hBFFF_FFFF);
    finishRecord(0);

    for (int t = 0; t < 60; t++) randomXfer();

    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

endmodule